// File: doc/BRIEF.md
# PCI Interrupt Steering Register Unit

This unit sits in the configuration space of a bridge function. It decides which legacy ISA interrupt request line each of eight interrupt sources lands on. The sources are the four shared PCI interrupt lines, the two native-mode disk channels, the power-management controller and the SMBus controller. Software writes a 4-bit steering code per source through a byte-wide configuration port. A steering code is not an IRQ number. It indexes a fixed, scrambled table in which several entries, and code 0, select no line at all.

Each source's request is OR-ed onto the ISA line its code selects, and the 16-bit request vector is registered once. Several sources may share a line. The port also carries two protection controls. A hide bit blanks every read in the upper half of the space. A lock bit freezes the command byte and blanks reads of it.

Top module: `pirq_steer`

## Requirements
- R1: A steering code c selects ISA IRQ as follows: 1→9, 2→3, 3→10, 4→4, 5→5, 6→7, 7→6, 8→1, 9→11, 11→12, 13→14, 15→15; the source's request then drives bit IRQ of `irq_o`. IRQ 0, 2, 8 and 13 are never driven.
- R2: Code 0 and codes 10, 12 and 14 connect the source to nothing, so its request leaves `irq_o` unaffected.
- R3: `src_req_i` bit order is INTA, INTB, INTC, INTD, disk channel 0, disk channel 1, power management, SMBus (bit 0 to 7). Their codes are taken from: 0x48[3:0], 0x48[7:4], 0x49[3:0], 0x49[7:4], 0x44[3:0], 0x75[3:0], 0x76[3:0] and 0x77[3:0].
- R4: Requests of several sources steered to the same IRQ are OR-ed onto that bit, and requests steered to different IRQs appear together.
- R5: Registers 0x75, 0x76 and 0x77 store only bits 4:0 of a write, so bits 7:5 read back as 0. Registers 0x44, 0x48, 0x49, 0x42 and 0x5F store the whole byte. `cfg_rdata_o` shows the addressed register combinationally.
- R6: While bit 7 of 0x42 is 1, every read at offset 0x40 or above returns 0. Offsets below 0x40 still read normally, and writes anywhere still take effect.
- R7: While bit 3 of 0x5F is 1, offset 0x04 reads as 0 and writes to it are dropped.
- R8: After reset every steering register, 0x42 and 0x5F are 0, `irq_o` is 0, and 0x04 reads as the parameter `CMD_RST` (default 0x0F).
- R9: `irq_o` is registered. It reflects requests and codes present before the preceding rising clock edge.
- R10: Any other offset reads as 0 and ignores writes.
- R11: `route_code_o` carries the eight current codes, four bits each, source 0 in bits 3:0 through source 7 in bits 31:28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data for `cfg_addr_i` |
| src_req_i | input | 8 | Interrupt requests of the eight sources, active high |
| irq_o | output | 16 | ISA IRQ request vector, bit n is IRQ n |
| route_code_o | output | 32 | Current steering code of every source |

## Verification
The hardest state to reach is a write that must take effect while reads cannot show it. The stimulus writes a steering register while the hide bit is set. It proves the write landed first through `irq_o`, by raising the source steered by the new code. It then proves it through a read-back after the hide bit is cleared. The lock is handled the same way: the command byte is written while locked and read after unlocking. The full code space is swept on one source, so that the dead codes and the scrambled order are both covered.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int CODE_W = 4;

    localparam logic [7:0] OFF_CMD     = 8'h04;
    localparam logic [7:0] OFF_HIDE    = 8'h42;
    localparam logic [7:0] OFF_RT_IDE0 = 8'h44;
    localparam logic [7:0] OFF_RT_AB   = 8'h48;
    localparam logic [7:0] OFF_RT_CD   = 8'h49;
    localparam logic [7:0] OFF_LOCK    = 8'h5F;
    localparam logic [7:0] OFF_RT_IDE1 = 8'h75;
    localparam logic [7:0] OFF_RT_PM   = 8'h76;
    localparam logic [7:0] OFF_RT_SMB  = 8'h77;
    localparam logic [7:0] HIDE_FLOOR  = 8'h40;
    localparam logic [7:0] NARROW_MASK = 8'h1F;
    localparam int         HIDE_BIT    = 7;
    localparam int         LOCK_BIT    = 3;

    typedef struct packed {
        logic              hit;
        logic [CODE_W-1:0] num;
    } irq_sel_t;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] hide_ctl;
        logic [7:0] lock_ctl;
        logic [7:0] rt_ab;
        logic [7:0] rt_cd;
        logic [7:0] rt_ide0;
        logic [7:0] rt_ide1;
        logic [7:0] rt_pm;
        logic [7:0] rt_smb;
    } cfg_regs_t;

    // Scrambled steering table; misses leave the source unconnected.
    function automatic irq_sel_t code_to_irq(input logic [CODE_W-1:0] code);
        irq_sel_t s;
        s.hit = 1'b1;
        case (code)
            4'd1:    s.num = 4'd9;
            4'd2:    s.num = 4'd3;
            4'd3:    s.num = 4'd10;
            4'd4:    s.num = 4'd4;
            4'd5:    s.num = 4'd5;
            4'd6:    s.num = 4'd7;
            4'd7:    s.num = 4'd6;
            4'd8:    s.num = 4'd1;
            4'd9:    s.num = 4'd11;
            4'd11:   s.num = 4'd12;
            4'd13:   s.num = 4'd14;
            4'd15:   s.num = 4'd15;
            default: begin
                s.hit = 1'b0;
                s.num = 4'd0;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pirq_code_decode.sv
module pirq_code_decode
    import pirq_pkg::*;
#(
    parameter int IRQ_W = 16
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [IRQ_W-1:0]  vec_o
);

    irq_sel_t sel;

    always_comb begin
        sel = code_to_irq(code_i);
        for (int i = 0; i < IRQ_W; i++) begin
            vec_o[i] = sel.hit && (int'(sel.num) == i);
        end
    end

endmodule

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
    import pirq_pkg::*;
#(
    parameter logic [7:0] CMD_RST = 8'h0F,
    parameter int         NUM_SRC = 8,
    localparam int        CODES_W = NUM_SRC * CODE_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               we_i,
    input  logic [7:0]         addr_i,
    input  logic [7:0]         wdata_i,
    output logic [7:0]         rdata_o,
    output logic [CODES_W-1:0] codes_o
);

    cfg_regs_t regs_d, regs_q;
    logic      hidden, locked;

    assign hidden = regs_q.hide_ctl[HIDE_BIT];
    assign locked = regs_q.lock_ctl[LOCK_BIT];

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            case (addr_i)
                OFF_CMD:     if (!locked) regs_d.cmd = wdata_i;
                OFF_HIDE:    regs_d.hide_ctl = wdata_i;
                OFF_LOCK:    regs_d.lock_ctl = wdata_i;
                OFF_RT_AB:   regs_d.rt_ab    = wdata_i;
                OFF_RT_CD:   regs_d.rt_cd    = wdata_i;
                OFF_RT_IDE0: regs_d.rt_ide0  = wdata_i;
                OFF_RT_IDE1: regs_d.rt_ide1  = wdata_i & NARROW_MASK;
                OFF_RT_PM:   regs_d.rt_pm    = wdata_i & NARROW_MASK;
                OFF_RT_SMB:  regs_d.rt_smb   = wdata_i & NARROW_MASK;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q     <= '0;
            regs_q.cmd <= CMD_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFF_CMD:     rdata_o = locked ? 8'h00 : regs_q.cmd;
            OFF_HIDE:    rdata_o = regs_q.hide_ctl;
            OFF_LOCK:    rdata_o = regs_q.lock_ctl;
            OFF_RT_AB:   rdata_o = regs_q.rt_ab;
            OFF_RT_CD:   rdata_o = regs_q.rt_cd;
            OFF_RT_IDE0: rdata_o = regs_q.rt_ide0;
            OFF_RT_IDE1: rdata_o = regs_q.rt_ide1;
            OFF_RT_PM:   rdata_o = regs_q.rt_pm;
            OFF_RT_SMB:  rdata_o = regs_q.rt_smb;
            default:     rdata_o = '0;
        endcase
        if (hidden && (addr_i >= HIDE_FLOOR)) rdata_o = '0;
    end

    assign codes_o = {regs_q.rt_smb[3:0], regs_q.rt_pm[3:0],
                      regs_q.rt_ide1[3:0], regs_q.rt_ide0[3:0],
                      regs_q.rt_cd[7:4], regs_q.rt_cd[3:0],
                      regs_q.rt_ab[7:4], regs_q.rt_ab[3:0]};

    // A locked command byte must not move on a write to it.
    assert_lock_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == OFF_CMD && locked) |=> $stable(regs_q.cmd));

    // A routing write lands whatever the hide bit says.
    assert_route_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == OFF_RT_AB) |=> (regs_q.rt_ab == $past(wdata_i)));

endmodule

// File: rtl/pirq_steer.sv
module pirq_steer
    import pirq_pkg::*;
#(
    parameter int         IRQ_W   = 16,
    parameter logic [7:0] CMD_RST = 8'h0F,
    localparam int        NUM_SRC = 8,
    localparam int        CODES_W = NUM_SRC * CODE_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cfg_we_i,
    input  logic [7:0]         cfg_addr_i,
    input  logic [7:0]         cfg_wdata_i,
    output logic [7:0]         cfg_rdata_o,
    input  logic [NUM_SRC-1:0] src_req_i,
    output logic [IRQ_W-1:0]   irq_o,
    output logic [CODES_W-1:0] route_code_o
);

    localparam logic [IRQ_W-1:0] DEAD_IRQS = IRQ_W'(16'h2105);

    typedef struct packed {
        logic [IRQ_W-1:0] irq;
    } steer_st_t;

    steer_st_t        st_d, st_q;
    logic [IRQ_W-1:0] src_vec [NUM_SRC];

    pirq_cfg_regs #(
        .CMD_RST (CMD_RST),
        .NUM_SRC (NUM_SRC)
    ) regs_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .rdata_o (cfg_rdata_o),
        .codes_o (route_code_o)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        pirq_code_decode #(
            .IRQ_W (IRQ_W)
        ) dec_i (
            .code_i (route_code_o[s*CODE_W +: CODE_W]),
            .vec_o  (src_vec[s])
        );
    end

    always_comb begin
        st_d.irq = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (src_req_i[s]) st_d.irq = st_d.irq | src_vec[s];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    assert_dead_lines_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((irq_o & DEAD_IRQS) == '0));

    assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_req_i == '0) |=> (irq_o == '0));

    assert_no_route_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (route_code_o == '0) |=> (irq_o == '0));

    assert_merge_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ($countones(irq_o) <= $countones($past(src_req_i))));

endmodule

// File: tb/pirq_steer_tb.sv
`timescale 1ns/100ps
module pirq_steer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wd = '0;
    logic [7:0]  rdata;
    logic [7:0]  src = '0;
    logic [15:0] irq;
    logic [31:0] route;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pirq_steer dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cfg_we_i     (we),
        .cfg_addr_i   (addr),
        .cfg_wdata_i  (wd),
        .cfg_rdata_o  (rdata),
        .src_req_i    (src),
        .irq_o        (irq),
        .route_code_o (route)
    );

    // Behavioural reference: byte map plus lookup list.
    int          tbl [16] = '{-1, 9, 3, 10, 4, 5, 7, 6, 1, 11, -1, 12, -1, 14, -1, 15};
    logic [7:0]  m [256];
    logic [15:0] exp_irq;

    function automatic logic [3:0] mcode(int s);
        case (s)
            0: return m[8'h48][3:0];
            1: return m[8'h48][7:4];
            2: return m[8'h49][3:0];
            3: return m[8'h49][7:4];
            4: return m[8'h44][3:0];
            5: return m[8'h75][3:0];
            6: return m[8'h76][3:0];
            default: return m[8'h77][3:0];
        endcase
    endfunction

    function automatic logic [7:0] mread(logic [7:0] a);
        if (a >= 8'h40 && m[8'h42][7]) return 8'h00;
        if (a == 8'h04 && m[8'h5F][3]) return 8'h00;
        return m[a];
    endfunction

    task automatic mreset();
        for (int i = 0; i < 256; i++) m[i] = 8'h00;
        m[8'h04] = 8'h0F;
        exp_irq = '0;
    endtask

    initial mreset();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mreset();
        end else begin
            logic [15:0] nx;
            nx = '0;
            for (int s = 0; s < 8; s++) begin
                int n;
                n = tbl[mcode(s)];
                if (src[s] && n >= 0) nx[n] = 1'b1;
            end
            exp_irq = nx;
            if (we) begin
                case (addr)
                    8'h04: if (!m[8'h5F][3]) m[8'h04] = wd;
                    8'h42, 8'h5F, 8'h44, 8'h48, 8'h49: m[addr] = wd;
                    8'h75, 8'h76, 8'h77: m[addr] = wd & 8'h1F;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, expv);
        end
    endtask

    // Per-cycle comparison against the reference.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] er;
            er = '0;
            for (int s = 0; s < 8; s++) er[s*4 +: 4] = mcode(s);
            chk("R9 irq", {16'h0, irq}, {16'h0, exp_irq});
            chk("R11 codes", route, er);
            chk("R5 read", {24'h0, rdata}, {24'h0, mread(addr)});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 20000 && !done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk); #0.5 addr = a; wd = d; we = 1'b1;
        @(negedge clk); #0.5 we = 1'b0;
    endtask

    task automatic rd(string tag, logic [7:0] a, logic [7:0] e);
        @(negedge clk); #0.5 addr = a;
        #0.5 chk(tag, {24'h0, rdata}, {24'h0, e});
    endtask

    task automatic setsrc(logic [7:0] v);
        @(negedge clk); #0.5 src = v;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        #0.5;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 irq in reset", {16'h0, irq}, 32'h0);
        #0.5 rst_n = 1'b1;
        chk("R8 codes", route, 32'h0);
        rd("R8 cmd", 8'h04, 8'h0F);
        rd("R8 route ab", 8'h48, 8'h00);
        rd("R8 hide", 8'h42, 8'h00);
        rd("R8 lock", 8'h5F, 8'h00);

        // R1/R2: sweep every code on INTA
        setsrc(8'h01);
        for (int c = 0; c < 16; c++) begin
            wr(8'h48, 8'(c));
            settle();
            if (tbl[c] < 0) chk("R2 dead code", {16'h0, irq}, 32'h0);
            else            chk("R1 code map", {16'h0, irq}, 32'(1) << tbl[c]);
        end
        wr(8'h48, 8'h02); settle();
        chk("R1 code2 to irq3", {16'h0, irq}, 32'h0008);
        wr(8'h48, 8'h0E); settle();
        chk("R2 code14 none", {16'h0, irq}, 32'h0);

        // R3: register and nibble layout
        wr(8'h48, 8'h00);
        wr(8'h49, 8'hD5);
        setsrc(8'h04); settle(); chk("R3 INTC", {16'h0, irq}, 32'h0020);
        setsrc(8'h08); settle(); chk("R3 INTD", {16'h0, irq}, 32'h4000);
        wr(8'h44, 8'hF3);
        setsrc(8'h10); settle(); chk("R3 disk0", {16'h0, irq}, 32'h0400);
        wr(8'h75, 8'hE8);
        setsrc(8'h20); settle(); chk("R3 disk1", {16'h0, irq}, 32'h0002);
        wr(8'h76, 8'h0F);
        setsrc(8'h40); settle(); chk("R3 pm", {16'h0, irq}, 32'h8000);
        wr(8'h77, 8'hB9);
        setsrc(8'h80); settle(); chk("R3 smb", {16'h0, irq}, 32'h0800);
        chk("R11 code vector", route, 32'h9F83D500);

        // R5: write masks
        rd("R5 0x75", 8'h75, 8'h08);
        rd("R5 0x77", 8'h77, 8'h19);
        rd("R5 0x76", 8'h76, 8'h0F);
        rd("R5 0x44", 8'h44, 8'hF3);
        rd("R5 0x49", 8'h49, 8'hD5);

        // R4: shared and distinct lines
        wr(8'h48, 8'h11);
        setsrc(8'h03); settle(); chk("R4 shared", {16'h0, irq}, 32'h0200);
        setsrc(8'h05); settle(); chk("R4 distinct", {16'h0, irq}, 32'h0220);

        // R9: one-cycle latency
        setsrc(8'h00); settle();
        setsrc(8'h01);
        #0.5 chk("R9 before edge", {16'h0, irq}, 32'h0);
        @(negedge clk); #0.5 chk("R9 after edge", {16'h0, irq}, 32'h0200);

        // R6: hide window
        wr(8'h42, 8'h80);
        rd("R6 hidden route", 8'h48, 8'h00);
        rd("R6 hidden ctl", 8'h42, 8'h00);
        rd("R6 low visible", 8'h04, 8'h0F);
        wr(8'h49, 8'h33);
        setsrc(8'h04); settle();
        chk("R6 write while hidden", {16'h0, irq}, 32'h0400);
        wr(8'h42, 8'h00);
        rd("R6 readback", 8'h49, 8'h33);

        // R7: command lock
        wr(8'h5F, 8'h08);
        rd("R7 locked read", 8'h04, 8'h00);
        wr(8'h04, 8'hA5);
        wr(8'h5F, 8'h00);
        rd("R7 write dropped", 8'h04, 8'h0F);
        wr(8'h04, 8'h5A);
        rd("R7 unlocked write", 8'h04, 8'h5A);

        // R10: unmapped offsets
        wr(8'h10, 8'hFF);
        rd("R10 low unmapped", 8'h10, 8'h00);
        wr(8'h60, 8'h77);
        rd("R10 high unmapped", 8'h60, 8'h00);

        // R8: reset mid-run
        setsrc(8'h01); settle();
        @(negedge clk); #0.5 rst_n = 1'b0;
        #0.5 chk("R8 async clear", {16'h0, irq}, 32'h0);
        repeat (2) @(negedge clk);
        #0.5 rst_n = 1'b1;
        rd("R8 route cleared", 8'h49, 8'h00);
        rd("R8 cmd restored", 8'h04, 8'h0F);
        settle();
        chk("R8 no route after reset", {16'h0, irq}, 32'h0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule